// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator

This block turns a free-running system clock into a periodic interrupt request for a CPU bus. A phase accumulator divides the clock down to one of two tick rates: a fast rate of 60 per second or a slow rate of 1 per second, chosen by a configuration pin. The average spacing between ticks is exactly the clock frequency divided by the rate, so the ticks do not drift over time, even when that division is not a whole number.

Each tick is shaped into a short pulse of fixed width, not a half-duty square wave. The rising edge of the pulse sets a request latch. The latch drives one line of an interrupt-level vector and stays set until the bus acknowledge arrives. The acknowledge input is synchronised and edge-detected, so each acknowledge clears at most one pending request.

A second source, the serial controller, drives its own line of the same vector at a higher level. Software can therefore tell the two sources apart. If a tick arrives while the previous request is still pending, a sticky missed-tick flag is raised for the host, which clears it with a dedicated input.

Top module: `tick_irq_gen`

## Requirements
- R1: While `rst_i` is high and in the first cycle after it, `tick_pulse_o`, `missed_o` and the tick line of `irq_lvl_o` are 0. Reset clears the divider phase, the pulse shaper and the request latch.
- R2: With `rate_slow_i` = 0 (fast rate, FAST_HZ = 60), successive rising edges of `tick_pulse_o` are CLK_HZ/60 cycles apart, rounded down or up. The sum of N consecutive gaps never drifts from N*CLK_HZ/60 by a full cycle. With the default CLK_HZ = 6000, every gap is 100 cycles.
- R3: With `rate_slow_i` = 1 (slow rate, SLOW_HZ = 1), successive rising edges of `tick_pulse_o` are CLK_HZ cycles apart (6000 with the defaults). After reset, the first tick comes CLK_HZ/rate cycles after reset is released.
- R4: Each tick holds `tick_pulse_o` high for exactly PULSE_CYC consecutive cycles (default 4).
- R5: The tick request appears on `irq_lvl_o[3]` (TICK_LVL = 3). It goes high on the cycle after `tick_pulse_o` rises and stays high until it is acknowledged.
- R6: A rising edge on `ack_i` clears a pending tick request. The request line goes low on the third clock edge after `ack_i` rises. Holding `ack_i` high does not clear a request set later; only a new rising edge does.
- R7: If a tick arrives while the request is still pending and no acknowledge clears it in that cycle, `missed_o` goes high and stays high. The request also stays high. A one-cycle pulse on `missed_clr_i` clears `missed_o`. If a new miss happens in the same cycle as the clear, the flag stays set.
- R8: `irq_lvl_o[5]` (SER_LVL = 5) follows `serial_irq_i` in the same cycle, whatever the tick state. Bits of `irq_lvl_o` other than 3 and 5 are always 0.
- R9: When a tick sets the request in the same cycle that an acknowledge edge clears it, the new request wins. The line stays high and `missed_o` is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rate_slow_i | input | 1 | Rate select: 0 = fast (60/s), 1 = slow (1/s) |
| ack_i | input | 1 | Bus interrupt acknowledge, asynchronous, active high |
| missed_clr_i | input | 1 | Host clear of the missed-tick flag |
| serial_irq_i | input | 1 | Request level from the serial controller |
| tick_pulse_o | output | 1 | Shaped tick pulse, PULSE_CYC cycles wide |
| irq_lvl_o | output | 8 | Interrupt-level vector: bit 3 is the tick request, bit 5 is the serial request |
| missed_o | output | 1 | Sticky flag: a tick arrived while the request was pending |

## Verification
The hardest case to reach from the ports is R9: a new tick setting the latch in exactly the cycle that an acknowledge edge clears it. The bench measures the tick period from the pulse edges. It then raises `ack_i` two cycles before the predicted next pulse rise, so that the three-edge acknowledge latency lands on the set cycle. It checks that the line stays high and `missed_o` stays low. The missed-tick flag is reached the simple way: by leaving a request unacknowledged across a full period.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;

  function automatic int width_for(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/tick_phase_acc.sv
module tick_phase_acc
  import tick_irq_pkg::*;
#(
  parameter int CLK_HZ  = 6000,
  parameter int FAST_HZ = 60,
  parameter int SLOW_HZ = 1
) (
  input  logic  clk_i,
  input  logic  rst_i,
  input  rate_e rate_i,
  output logic  strobe_o
);
  localparam int ACC_W = width_for(CLK_HZ + FAST_HZ + SLOW_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc;
  logic [ACC_W-1:0] sum;

  always_comb begin
    inc = (rate_i == RATE_SLOW) ? ACC_W'(SLOW_HZ) : ACC_W'(FAST_HZ);
    sum = acc_q + inc;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q    <= '0;
      strobe_o <= 1'b0;
    end else if (sum >= ACC_W'(CLK_HZ)) begin
      acc_q    <= sum - ACC_W'(CLK_HZ);
      strobe_o <= 1'b1;
    end else begin
      acc_q    <= sum;
      strobe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_pulse_shaper.sv
module tick_pulse_shaper
  import tick_irq_pkg::*;
#(
  parameter int PULSE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  output logic pulse_o
);
  localparam int CNT_W = width_for(PULSE_CYC);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      left_q <= '0;
    end else if (strobe_i) begin
      left_q <= CNT_W'(PULSE_CYC);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/ack_edge_sync.sv
module ack_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ack_i,
  output logic edge_o
);
  logic [SYNC_STAGES:0] sh_q;

  genvar s;
  generate
    for (s = 0; s <= SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) sh_q[s] <= 1'b0;
          else       sh_q[s] <= ack_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) sh_q[s] <= 1'b0;
          else       sh_q[s] <= sh_q[s-1];
        end
      end
    end
  endgenerate

  assign edge_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/tick_req_latch.sv
module tick_req_latch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pulse_i,
  input  logic ack_edge_i,
  input  logic missed_clr_i,
  output logic req_o,
  output logic missed_o
);
  logic pulse_d_q;
  logic set_now;

  assign set_now = pulse_i & ~pulse_d_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pulse_d_q <= 1'b0;
      req_o     <= 1'b0;
      missed_o  <= 1'b0;
    end else begin
      pulse_d_q <= pulse_i;
      if (set_now)         req_o <= 1'b1;
      else if (ack_edge_i) req_o <= 1'b0;
      if (set_now && req_o && !ack_edge_i) missed_o <= 1'b1;
      else if (missed_clr_i)               missed_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
  import tick_irq_pkg::*;
#(
  parameter int CLK_HZ      = 6000,
  parameter int FAST_HZ     = 60,
  parameter int SLOW_HZ     = 1,
  parameter int PULSE_CYC   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_LVL     = 8,
  parameter int TICK_LVL    = 3,
  parameter int SER_LVL     = 5
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               rate_slow_i,
  input  logic               ack_i,
  input  logic               missed_clr_i,
  input  logic               serial_irq_i,
  output logic               tick_pulse_o,
  output logic [NUM_LVL-1:0] irq_lvl_o,
  output logic               missed_o
);
  rate_e rate_sel;
  logic  strobe;
  logic  ack_edge;
  logic  tick_req;

  assign rate_sel = rate_e'(rate_slow_i);

  tick_phase_acc #(
    .CLK_HZ (CLK_HZ),
    .FAST_HZ(FAST_HZ),
    .SLOW_HZ(SLOW_HZ)
  ) u_div (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .rate_i  (rate_sel),
    .strobe_o(strobe)
  );

  tick_pulse_shaper #(.PULSE_CYC(PULSE_CYC)) u_shape (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .strobe_i(strobe),
    .pulse_o (tick_pulse_o)
  );

  ack_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .ack_i (ack_i),
    .edge_o(ack_edge)
  );

  tick_req_latch u_req (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .pulse_i     (tick_pulse_o),
    .ack_edge_i  (ack_edge),
    .missed_clr_i(missed_clr_i),
    .req_o       (tick_req),
    .missed_o    (missed_o)
  );

  genvar l;
  generate
    for (l = 0; l < NUM_LVL; l++) begin : g_lvl
      if (l == TICK_LVL) begin : g_tick
        assign irq_lvl_o[l] = tick_req;
      end else if (l == SER_LVL) begin : g_ser
        assign irq_lvl_o[l] = serial_irq_i;
      end else begin : g_idle
        assign irq_lvl_o[l] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/tick_irq_gen_chk.sv
module tick_irq_gen_chk #(
  parameter int CLK_HZ    = 6000,
  parameter int FAST_HZ   = 60,
  parameter int SLOW_HZ   = 1,
  parameter int PULSE_CYC = 4,
  parameter int NUM_LVL   = 8,
  parameter int TICK_LVL  = 3
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               rate_slow_i,
  input logic               tick_pulse_o,
  input logic [NUM_LVL-1:0] irq_lvl_o,
  input logic               missed_o,
  input logic               ack_edge
);
  localparam int FAST_LO = CLK_HZ / FAST_HZ;
  localparam int FAST_HI = FAST_LO + ((CLK_HZ % FAST_HZ) != 0 ? 1 : 0);
  localparam int SLOW_LO = CLK_HZ / SLOW_HZ;
  localparam int SLOW_HI = SLOW_LO + ((CLK_HZ % SLOW_HZ) != 0 ? 1 : 0);

  logic        pulse_d_q;
  logic        rate_d_q;
  logic        seen_q;
  logic        steady_q;
  int unsigned gap_q;
  int unsigned wid_q;
  logic        rise_now;
  logic        gap_ok;

  assign rise_now = tick_pulse_o & ~pulse_d_q;
  assign gap_ok   = rate_slow_i ? (gap_q >= SLOW_LO && gap_q <= SLOW_HI)
                                : (gap_q >= FAST_LO && gap_q <= FAST_HI);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pulse_d_q <= 1'b0;
      rate_d_q  <= rate_slow_i;
      seen_q    <= 1'b0;
      steady_q  <= 1'b0;
      gap_q     <= 0;
      wid_q     <= 0;
    end else begin
      pulse_d_q <= tick_pulse_o;
      rate_d_q  <= rate_slow_i;
      gap_q     <= rise_now ? 1 : gap_q + 1;
      wid_q     <= tick_pulse_o ? wid_q + 1 : 0;
      if (rise_now) begin
        seen_q   <= 1'b1;
        steady_q <= 1'b1;
      end else if (rate_slow_i != rate_d_q) begin
        steady_q <= 1'b0;
      end
    end
  end

  // R2 R3
  tick_period_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_now && seen_q && steady_q && rate_slow_i == rate_d_q) |-> gap_ok);

  // R4
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick_pulse_o && pulse_d_q) |-> (wid_q == PULSE_CYC));

  // R5
  req_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_now |=> irq_lvl_o[TICK_LVL]);

  // R6
  req_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_lvl_o[TICK_LVL] && !rise_now && !ack_edge) |=> irq_lvl_o[TICK_LVL]);

  // R7
  missed_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_now && irq_lvl_o[TICK_LVL] && !ack_edge) |=> (missed_o && irq_lvl_o[TICK_LVL]));

  // R9
  ack_race_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_now && ack_edge && !missed_o) |=> (irq_lvl_o[TICK_LVL] && !missed_o));
endmodule

bind tick_irq_gen tick_irq_gen_chk #(
  .CLK_HZ   (CLK_HZ),
  .FAST_HZ  (FAST_HZ),
  .SLOW_HZ  (SLOW_HZ),
  .PULSE_CYC(PULSE_CYC),
  .NUM_LVL  (NUM_LVL),
  .TICK_LVL (TICK_LVL)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .rate_slow_i (rate_slow_i),
  .tick_pulse_o(tick_pulse_o),
  .irq_lvl_o   (irq_lvl_o),
  .missed_o    (missed_o),
  .ack_edge    (ack_edge)
);

// File: tb/tick_irq_gen_bench.sv
module tick_irq_gen_bench;
  localparam int CLK_HZ = 6000;
  localparam int PULSE  = 4;
  localparam int P_FAST = 100;

  // each row: {rate_slow, expected gap between tick rises}
  localparam logic [16:0] ROWS [3] = '{
    {1'b0, 16'd100},
    {1'b1, 16'd6000},
    {1'b0, 16'd100}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rate_slow = 1'b0;
  logic       ack = 1'b0;
  logic       mclr = 1'b0;
  logic       ser = 1'b0;
  logic       pulse;
  logic [7:0] lvl;
  logic       missed;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_irq_gen u_tick_irq_gen (
    .clk_i       (clk),
    .rst_i       (rst),
    .rate_slow_i (rate_slow),
    .ack_i       (ack),
    .missed_clr_i(mclr),
    .serial_irq_i(ser),
    .tick_pulse_o(pulse),
    .irq_lvl_o   (lvl),
    .missed_o    (missed)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_rise(output int at);
    logic p;
    p = pulse;
    forever begin
      @(negedge clk);
      if (pulse && !p) break;
      p = pulse;
    end
    at = cyc;
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t0;
    int t1;
    int t2;
    int w;

    // R1 reset state
    repeat (2) @(negedge clk);
    check(pulse == 1'b0, "R1 pulse in reset", int'(pulse), 0);
    check(lvl[3] == 1'b0, "R1 tick line in reset", int'(lvl[3]), 0);
    check(missed == 1'b0, "R1 missed in reset", int'(missed), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pulse == 1'b0 && lvl[3] == 1'b0, "R1 first cycle after reset", int'(lvl), 0);

    // table walk: rate, period, pulse width, request rise
    foreach (ROWS[i]) begin
      rate_slow = ROWS[i][16];
      do_reset();
      t0 = cyc;
      wait_rise(t1);
      // first tick lands CLK_HZ/rate cycles after reset release (R2 R3)
      check((t1 - t0) >= int'(ROWS[i][15:0]) - 1 && (t1 - t0) <= int'(ROWS[i][15:0]) + 2,
            ROWS[i][16] ? "R3 first tick" : "R2 first tick", t1 - t0, int'(ROWS[i][15:0]));
      check(lvl[3] == 1'b0, "R5 request not yet set at pulse rise", int'(lvl[3]), 0);
      w = 1;
      @(negedge clk);
      check(lvl[3] == 1'b1, "R5 request set one cycle after rise", int'(lvl[3]), 1);
      while (pulse) begin
        w++;
        @(negedge clk);
      end
      check(w == PULSE, "R4 pulse width", w, PULSE);
      wait_rise(t2);
      check(t2 - t1 == int'(ROWS[i][15:0]), ROWS[i][16] ? "R3 period" : "R2 period",
            t2 - t1, int'(ROWS[i][15:0]));
      check(lvl[3] == 1'b1, "R5 request held without ack", int'(lvl[3]), 1);
      wait_rise(t1);
      check(t1 - t2 == int'(ROWS[i][15:0]), ROWS[i][16] ? "R3 period no drift" : "R2 period no drift",
            t1 - t2, int'(ROWS[i][15:0]));
    end

    // R7 missed flag and host clear, R9 ack race, R6 ack edges
    rate_slow = 1'b0;
    do_reset();
    wait_rise(t1);
    @(negedge clk);
    check(missed == 1'b0, "R7 no miss on first tick", int'(missed), 0);
    wait_rise(t2);
    repeat (2) @(negedge clk);
    check(missed == 1'b1 && lvl[3] == 1'b1, "R7 miss while pending", int'(missed), 1);
    wait_until(t2 + 5);
    mclr = 1'b1;
    @(negedge clk) mclr = 1'b0;
    check(missed == 1'b0 && lvl[3] == 1'b1, "R7 host clear keeps request", int'(missed), 0);

    // R9 ack edge lands on the set cycle of the next tick at t2 + P_FAST
    wait_until(t2 + P_FAST - 2);
    ack = 1'b1;
    wait_until(t2 + P_FAST + 1);
    check(pulse == 1'b1, "R9 tick arrived as predicted", int'(pulse), 1);
    check(lvl[3] == 1'b1, "R9 new request wins over ack", int'(lvl[3]), 1);
    check(missed == 1'b0, "R9 no miss on ack race", int'(missed), 0);

    // R6 held ack does not clear the next request
    wait_rise(t1);
    repeat (4) @(negedge clk);
    check(lvl[3] == 1'b1, "R6 held ack does not clear again", int'(lvl[3]), 1);
    ack = 1'b0;
    repeat (3) @(negedge clk);
    ack = 1'b1;
    t0 = cyc;
    repeat (2) @(negedge clk);
    check(lvl[3] == 1'b1, "R6 still set before sync latency", int'(lvl[3]), 1);
    @(negedge clk);
    check(lvl[3] == 1'b0, "R6 cleared on third edge after ack", int'(lvl[3]), 0);
    ack = 1'b0;

    // R8 serial line independent of tick state
    ser = 1'b1;
    #1;
    check(lvl == 8'h20, "R8 serial only", int'(lvl), 32);
    wait_rise(t1);
    @(negedge clk);
    check(lvl == 8'h28, "R8 serial with tick pending", int'(lvl), 40);
    ser = 1'b0;
    #1;
    check(lvl == 8'h08, "R8 serial dropped", int'(lvl), 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule